// File: doc/BRIEF.md
# Programmable Reference Clock Generator

This block derives a slower clock from the system clock and drives it onto a shared output pin. A 3-bit ratio field divides the system clock by a power of two from 1 up to 128. A 2-bit field sets the share of each divided period that the output spends high. The block runs only while its module enable is set. A separate output gate decides whether the result reaches the pin. The ratio and duty fields are taken into use only at the start of a divided period, so a reconfiguration never produces a runt pulse.

The pin is shared. A fixed system-clock/4 output has first claim on it. A crystal or resonator oscillator mode that uses the pin as an oscillator input comes next, and in that case the pin is not driven high. The reference clock comes last. While the sleep input is high, all counters and held configuration stay frozen, as they would if the system clock had stopped, so the pin keeps its level until sleep ends.

Top module: `refclk_gen`

## Requirements
- R1: While reset is low at a rising edge, and after it, the module is disabled and its held ratio, duty and counters are cleared. With the /4 override off, the pin is low until the module is enabled.
- R2: When the module enable is low, the reference path is stopped and the pin is low (override and oscillator flags low). The enable is sampled at the rising edge.
- R3: When the output gate is low, the pin is low even while the divider runs. The gate acts combinationally on the pin.
- R4: Ratio code k (0 to 7) gives a period of 2^k system clock cycles. Each period starts with its high phase, and the first period begins in the cycle after the edge that samples the enable high.
- R5: For ratios of 4 and above, duty code 00 holds the output low, 01 gives N/4 high cycles, 10 gives N/2 and 11 gives 3N/4, counted from the start of the period.
- R6: At ratio 1 (code 0), every nonzero duty code passes the system clock level straight to the output, and code 00 holds it low.
- R7: At ratio 2 (code 1), every nonzero duty code gives one high cycle followed by one low cycle.
- R8: When the /4 override input is high, the pin carries a free-running system-clock/4 square wave (two cycles high, two low), whatever the other inputs are. Its counter starts from zero at reset, and its high half is the second half of each 4-cycle count.
- R9: When the oscillator-owns-pin flag is high and the override is low, the pin is low.
- R10: A ratio or duty change made in the middle of a period does not take effect until the edge that ends that period.
- R11: While sleep is high at a rising edge, every counter and held field keeps its value and the enable is not resampled. At ratio 1 the output stays high, which is the level of the stopped clock after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the divider source |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | Freeze request: clock considered stopped |
| mod_en | input | 1 | Module enable |
| out_en | input | 1 | Gate from the reference clock to the pin |
| div_sel | input | 3 | Ratio code, period 2^code |
| duty_sel | input | 2 | Duty code: 00 off, 01 25%, 10 50%, 11 75% |
| sysout_en | input | 1 | Force system-clock/4 onto the pin |
| xtal_own | input | 1 | Pin taken by an oscillator mode |
| pin_out | output | 1 | Pin drive value |

## Verification
The ratio codes are swept with a fixed duty so that each period length can be told apart, then the four duty codes are run at a mid ratio to separate high-time quarters. Ratio 1 and ratio 2 get their own runs, because there the duty field either passes the clock through or collapses to 50%. A mid-period ratio change, sleep at both counted and pass-through ratios, and each of the three pin-priority inputs show when held state moves and which source owns the pin. A seeded random phase then mixes all fields, sleeps and resets at arbitrary times against a cycle model, which catches boundary and priority slips that the directed runs do not hit.

// File: rtl/refclk_pkg.sv
// Shared types for the reference clock generator.
// Assumes the duty field is exactly two bits wide.
package refclk_pkg;
    typedef enum logic [1:0] {
        DUTY_OFF  = 2'b00,
        DUTY_Q1   = 2'b01,
        DUTY_HALF = 2'b10,
        DUTY_Q3   = 2'b11
    } duty_e;
endpackage

// File: rtl/refclk_quarter.sv
// Free-running system-clock/4 source for the pin override.
// Assumes sleep freezes the count, as a stopped system clock would.
module refclk_quarter #(
    parameter int PRE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic q_lvl
);
    logic [PRE_W-1:0] pre;

    // Count system clocks unless asleep.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre <= '0;
        else if (!sleep) pre <= pre + 1'b1;
    end

    assign q_lvl = pre[PRE_W-1];

    // R11
    quarter_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(pre));
endmodule

// File: rtl/refclk_div.sv
// Power-of-two divider with selectable duty. The ratio and duty are held
// and reloaded only at a period boundary or while disabled. Ratio 1
// passes the clock level through. Assumes a synchronous sleep input.
module refclk_div
    import refclk_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             mod_en,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [1:0]       duty_sel,
    output logic             run,
    output logic             ref_lvl
);
    localparam int CNT_W = (1 << DIV_W) - 1;
    localparam int PER_W = CNT_W + 1;

    logic             en_q, sleep_q, wrap;
    logic [DIV_W-1:0] act_div;
    duty_e            act_duty;
    logic [CNT_W-1:0] cnt, last;
    logic [PER_W-1:0] period, hi_cnt;

    // Period length and last count for the held ratio.
    always_comb begin
        period = PER_W'(1) << act_div;
        last   = CNT_W'(period - 1'b1);
        wrap   = (cnt == last);
    end

    // High-cycle count for the held duty; ratio 2 rounds to one cycle.
    always_comb begin
        case (act_duty)
            DUTY_OFF:  hi_cnt = '0;
            DUTY_Q1:   hi_cnt = period >> 2;
            DUTY_HALF: hi_cnt = period >> 1;
            default:   hi_cnt = (period >> 1) + (period >> 2);
        endcase
        if (act_duty != DUTY_OFF && act_div <= DIV_W'(1)) hi_cnt = PER_W'(1);
    end

    // Sample enable, reload fields at boundaries, advance the phase count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            sleep_q  <= 1'b0;
            act_div  <= '0;
            act_duty <= DUTY_OFF;
            cnt      <= '0;
        end else begin
            sleep_q <= sleep;
            if (!sleep) begin
                en_q <= mod_en;
                if (!en_q || wrap) begin
                    act_div  <= div_sel;
                    act_duty <= duty_e'(duty_sel);
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Output level: pass-through at ratio 1, compare otherwise.
    always_comb begin
        if (!en_q)                ref_lvl = 1'b0;
        else if (act_div == '0)   ref_lvl = (act_duty != DUTY_OFF) && (clk || sleep_q);
        else                      ref_lvl = (PER_W'(cnt) < hi_cnt);
    end

    assign run = en_q;

    // R11
    div_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(cnt) && $stable(act_div) && $stable(act_duty) && $stable(en_q)));
    // R10
    mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !wrap) |=> ($stable(act_div) && $stable(act_duty)));
    // R4
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= last));
    // R2
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !sleep) |=> (cnt == '0));
endmodule

// File: rtl/refclk_pinmux.sv
// Pin owner selection: the /4 override first, then an oscillator claim,
// then the gated reference clock. Purely combinational.
module refclk_pinmux (
    input  logic sysout_en,
    input  logic xtal_own,
    input  logic out_en,
    input  logic run,
    input  logic ref_lvl,
    input  logic q_lvl,
    output logic pin
);
    // Priority select of the pin drive value.
    always_comb begin
        if (sysout_en)          pin = q_lvl;
        else if (xtal_own)      pin = 1'b0;
        else if (out_en && run) pin = ref_lvl;
        else                    pin = 1'b0;
    end
endmodule

// File: rtl/refclk_gen.sv
// Top of the reference clock generator: divider, /4 override source
// and pin mux. Assumes all control inputs are synchronous to clk.
module refclk_gen #(
    parameter int DIV_W = 3,
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             mod_en,
    input  logic             out_en,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [1:0]       duty_sel,
    input  logic             sysout_en,
    input  logic             xtal_own,
    output logic             pin_out
);
    logic run, ref_lvl, q_lvl;

    refclk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .mod_en(mod_en),
        .div_sel(div_sel), .duty_sel(duty_sel), .run(run), .ref_lvl(ref_lvl)
    );

    refclk_quarter #(.PRE_W(PRE_W)) u_quarter (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .q_lvl(q_lvl)
    );

    refclk_pinmux u_mux (
        .sysout_en(sysout_en), .xtal_own(xtal_own), .out_en(out_en),
        .run(run), .ref_lvl(ref_lvl), .q_lvl(q_lvl), .pin(pin_out)
    );
endmodule

// File: tb/refclk_gen_test.sv
module refclk_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, sleep = 1'b0, mod_en = 1'b0, out_en = 1'b0;
    logic [2:0] div_sel = '0;
    logic [1:0] duty_sel = '0;
    logic       sysout_en = 1'b0, xtal_own = 1'b0;
    logic       pin_out;

    int checks = 0, errors = 0, cycles = 0;
    bit chk_on = 0;
    string phase_tag = "";

    // cycle model state
    bit       m_en, m_sleep;
    int       m_cnt, m_div, m_duty, m_q;

    refclk_gen uut (.*);

    always #4 clk = ~clk;

    function automatic int exp_hi(int d, int du);
        int n = 1 << d;
        if (du == 0) return 0;
        if (d <= 1) return 1;
        if (du == 1) return n / 4;
        if (du == 2) return n / 2;
        return 3 * n / 4;
    endfunction

    function automatic bit exp_pin(bit ph);
        bit r;
        if (sysout_en) return m_q[1];
        if (xtal_own) return 1'b0;
        if (!(out_en && m_en)) return 1'b0;
        if (m_div == 0) r = (m_duty != 0) && (ph || m_sleep);
        else r = (m_cnt < exp_hi(m_div, m_duty));
        return r;
    endfunction

    function automatic string cur_tag();
        if (phase_tag != "") return phase_tag;
        if (sysout_en) return "R8";
        if (xtal_own) return "R9";
        if (!m_en) return "R2";
        if (!out_en) return "R3";
        if (m_sleep) return "R11";
        if (m_div == 0) return "R6";
        if (m_div == 1) return "R7";
        return "R5";
    endfunction

    // model update at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_en = 0; m_sleep = 0; m_cnt = 0; m_div = 0; m_duty = 0; m_q = 0;
        end else begin
            m_sleep = sleep;
            if (!sleep) begin
                m_q = (m_q + 1) % 4;
                if (!m_en || m_cnt == (1 << m_div) - 1) begin
                    m_div = div_sel; m_duty = duty_sel; m_cnt = 0;
                end else m_cnt++;
                m_en = mod_en;
            end
        end
    end

    task automatic check(bit ph);
        bit e = exp_pin(ph);
        checks++;
        if (pin_out !== e) begin
            errors++;
            $display("FAIL %s: pin_out=%b expected %b at %0t", cur_tag(), pin_out, e, $time);
        end
    endtask

    always @(posedge clk) if (chk_on) begin #2; check(1'b1); end
    always @(negedge clk) if (chk_on) begin #2; check(1'b0); end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(bit en, bit oe, int d, int du);
        mod_en = en; out_en = oe; div_sel = 3'(d); duty_sel = 2'(du);
    endtask

    // watchdog
    initial begin
        wait (cycles > 200000);
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below 200000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(posedge clk);
        chk_on = 1;
        // R1 reset state, with fields presented at the inputs
        phase_tag = "R1";
        cfg(1, 1, 3, 2);
        wait_cyc(3);
        rst_n = 1'b1; cfg(0, 1, 3, 2);
        wait_cyc(3);
        phase_tag = "";
        // R8 override while the divider runs
        cfg(1, 1, 2, 1); sysout_en = 1; wait_cyc(12);
        sysout_en = 0;
        // R2 module disabled
        cfg(0, 1, 2, 2); wait_cyc(8);
        // R4 ratio sweep
        phase_tag = "R4";
        for (int d = 0; d < 8; d++) begin
            cfg(1, 1, d, 2); wait_cyc(2 * (1 << d) + 4);
        end
        cfg(0, 1, 0, 0); wait_cyc(3);
        phase_tag = "";
        // R5 duty codes at ratio 8
        for (int du = 0; du < 4; du++) begin cfg(1, 1, 3, du); wait_cyc(20); end
        // R6 pass-through and R7 ratio 2
        for (int du = 0; du < 4; du++) begin cfg(1, 1, 0, du); wait_cyc(6); end
        for (int du = 0; du < 4; du++) begin cfg(1, 1, 1, du); wait_cyc(6); end
        // R10 change in mid period
        cfg(0, 1, 5, 2); wait_cyc(2);
        cfg(1, 1, 5, 2); wait_cyc(10);
        phase_tag = "R10";
        cfg(1, 1, 2, 3); wait_cyc(40);
        phase_tag = "";
        // R3 gate low while running
        cfg(1, 0, 2, 2); wait_cyc(8);
        // R9 oscillator claim
        cfg(1, 1, 2, 2); xtal_own = 1; wait_cyc(8); xtal_own = 0;
        // R11 sleep at ratio 16 and at ratio 1
        cfg(1, 1, 4, 1); wait_cyc(5);
        sleep = 1; mod_en = 0; wait_cyc(9); sleep = 0; mod_en = 1; wait_cyc(20);
        cfg(1, 1, 0, 3); wait_cyc(4);
        sleep = 1; wait_cyc(5); sleep = 0; wait_cyc(4);
        // random mix
        for (int i = 0; i < 60; i++) begin
            cfg($urandom_range(0, 9) != 0, $urandom_range(0, 5) != 0,
                $urandom_range(0, 7), $urandom_range(0, 3));
            sysout_en = ($urandom_range(0, 7) == 0);
            xtal_own  = ($urandom_range(0, 7) == 0);
            for (int k = $urandom_range(1, 300); k > 0; k--) begin
                sleep = ($urandom_range(0, 30) == 0);
                if ($urandom_range(0, 250) == 0) begin
                    rst_n = 0; wait_cyc(1); rst_n = 1;
                end
                if ($urandom_range(0, 40) == 0) duty_sel = 2'($urandom_range(0, 3));
                wait_cyc(1);
            end
            sleep = 0;
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule